// File: doc/BRIEF.md
# FIFO Trigger-Level Status Flags

This block produces two sticky status flags for a serial port that has 16-entry transmit and receive FIFOs. The transmit-space flag indicates that the transmit FIFO has drained to its programmed threshold or below. The receive-level flag indicates that the receive FIFO has filled to its programmed threshold or above. Each threshold comes from a 2-bit select field. The block takes the occupancy counts as inputs and does not contain the FIFOs.

Software reaches the block through a small register port. Address 0 returns the two flags. Address 1 returns both occupancy counts packed into one word. A flag can be cleared only by a read that observed it as 1, followed by a write of 0 to its bit. The flags are level-driven, so when the FIFO level still meets the threshold at the moment of the clear, the flag stays at 1. An interrupt request combines each flag with its own enable.

Top module: `fifo_level_flags`

## Requirements
- R1: While reset is asserted, both flags and `irq` are 0.
- R2: One clock edge after `tx_count` is at or below the transmit threshold, `tx_flag` is 1. The select `tx_sel` encodes the threshold as 0→8, 1→4, 2→2 and 3→1 entries.
- R3: One clock edge after `rx_count` is at or above the receive threshold, `rx_flag` is 1. The select `rx_sel` encodes the threshold as 0→1, 1→4, 2→8 and 3→14 entries.
- R4: A flag that is 1 stays 1 after its level condition goes away, until a valid clear removes it.
- R5: A write to address 0 with bit 0 (transmit) or bit 1 (receive) at 0 clears that flag at the next edge. This only happens when the flag was read as 1 at address 0 since it was last cleared. Writing 1 to a bit has no effect.
- R6: A clear write with no such read is ignored. After each clear, a new read is needed before another clear takes effect.
- R7: A valid clear issued while the level condition still holds leaves the flag at 1.
- R8: A read of address 0 returns `tx_flag` in bit 0, `rx_flag` in bit 1 and zeros elsewhere. A read of address 1 returns `tx_count` in bits [15:8] and `rx_count` in bits [7:0].
- R9: `irq` is 1 exactly when (`tx_flag` and `tx_ie`) or (`rx_flag` and `rx_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count | input | 5 | Transmit FIFO occupancy |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_sel | input | 2 | Transmit threshold select |
| rx_sel | input | 2 | Receive threshold select |
| tx_ie | input | 1 | Transmit flag interrupt enable |
| rx_ie | input | 1 | Receive flag interrupt enable |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flags, 1 = counts |
| reg_wdata | input | 2 | Write data, bit 0 transmit, bit 1 receive |
| reg_rdata | output | 16 | Read data (combinational) |
| tx_flag | output | 1 | Transmit-space flag |
| rx_flag | output | 1 | Receive-level flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default depth of 16 with 8-bit count fields. With these values all four threshold encodings of each select can be tested exactly at the boundary. This includes the 1-entry transmit threshold and the 14-entry receive threshold near a full FIFO, and the full count of 16 in the packed register. Each threshold is tested on both sides of its boundary. The read-then-clear handshake is tested with the level condition still active and with it inactive.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH   = 16,
  parameter int FIELD_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic [1:0]               tx_sel,
  input  logic [1:0]               rx_sel,
  input  logic                     tx_ie,
  input  logic                     rx_ie,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic                     reg_addr,
  input  logic [1:0]               reg_wdata,
  output logic [2*FIELD_W-1:0]     reg_rdata,
  output logic                     tx_flag,
  output logic                     rx_flag,
  output logic                     irq
);
  localparam int CW = $clog2(DEPTH+1);

  function automatic logic [CW-1:0] tx_level(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(8);
      2'd1:    return CW'(4);
      2'd2:    return CW'(2);
      default: return CW'(1);
    endcase
  endfunction

  function automatic logic [CW-1:0] rx_level(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(1);
      2'd1:    return CW'(4);
      2'd2:    return CW'(8);
      default: return CW'(14);
    endcase
  endfunction

  logic tx_cond, rx_cond, tx_seen, rx_seen, st_rd, st_wr, tx_clr, rx_clr;

  assign tx_cond = tx_count <= tx_level(tx_sel);
  assign rx_cond = rx_count >= rx_level(rx_sel);
  assign st_rd   = reg_rd && !reg_addr;
  assign st_wr   = reg_wr && !reg_addr;
  assign tx_clr  = st_wr && !reg_wdata[0] && tx_seen;
  assign rx_clr  = st_wr && !reg_wdata[1] && rx_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
      tx_seen <= 1'b0;
      rx_seen <= 1'b0;
    end else begin
      tx_flag <= tx_clr ? tx_cond : (tx_flag | tx_cond);
      rx_flag <= rx_clr ? rx_cond : (rx_flag | rx_cond);
      if (tx_clr)                  tx_seen <= 1'b0;
      else if (st_rd && tx_flag)   tx_seen <= 1'b1;
      if (rx_clr)                  rx_seen <= 1'b0;
      else if (st_rd && rx_flag)   rx_seen <= 1'b1;
    end
  end

  assign reg_rdata = reg_addr ? {FIELD_W'(tx_count), FIELD_W'(rx_count)}
                              : {{(2*FIELD_W-2){1'b0}}, rx_flag, tx_flag};
  assign irq = (tx_flag && tx_ie) || (rx_flag && rx_ie);

  // R2
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cond |=> tx_flag);
  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond |=> rx_flag);
  // R5
  tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> $past(st_wr && !reg_wdata[0]));
  // R5
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(st_wr && !reg_wdata[1]));
  // R6
  tx_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !tx_seen) |=> tx_flag);
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && !rx_ie) |-> !irq);
endmodule

// File: tb/fifo_level_flags_bench.sv
module fifo_level_flags_bench;
  logic clk = 0, rst_n = 0;
  logic [4:0] tx_count = 0, rx_count = 0;
  logic [1:0] tx_sel = 0, rx_sel = 0, reg_wdata = 0;
  logic tx_ie = 0, rx_ie = 0, reg_rd = 0, reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_rdata;
  logic tx_flag, rx_flag, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fifo_level_flags u_fifo_level_flags (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_addr = 0;
  endtask

  task automatic wr(logic [1:0] d);
    reg_wr = 1; reg_addr = 0; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 tx", tx_flag, 0); chk("R1 rx", rx_flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1; @(negedge clk);
  endtask

  task automatic t_tx_levels;
    logic [15:0] d;
    int lv[4] = '{8, 4, 2, 1};
    for (int s = 0; s < 4; s++) begin
      tx_sel = 2'(s); tx_count = 5'(lv[s] + 1); @(negedge clk);
      rd(0, d); wr(2'b10);
      chk("R5 tx clear above threshold", tx_flag, 0);
      tx_count = 5'(lv[s]); @(negedge clk);
      chk("R2 tx at threshold", tx_flag, 1);
      tx_count = 16; @(negedge clk);
      chk("R4 tx sticky", tx_flag, 1);
      rd(0, d); wr(2'b10);
    end
  endtask

  task automatic t_rx_levels;
    logic [15:0] d;
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      rx_sel = 2'(s); rx_count = 5'(lv[s] - 1); @(negedge clk);
      rd(0, d); wr(2'b01);
      chk("R5 rx clear below threshold", rx_flag, 0);
      rx_count = 5'(lv[s]); @(negedge clk);
      chk("R3 rx at threshold", rx_flag, 1);
      rx_count = 0; @(negedge clk);
      chk("R4 rx sticky", rx_flag, 1);
      rd(0, d); wr(2'b01);
      chk("R5 rx cleared", rx_flag, 0);
    end
  endtask

  task automatic t_handshake;
    logic [15:0] d;
    tx_sel = 0; tx_count = 3; @(negedge clk);
    tx_count = 12; @(negedge clk);
    wr(2'b00);
    chk("R6 tx clear without read", tx_flag, 1);
    rd(0, d); chk("R8 status read", d, 16'h0001);
    wr(2'b11);
    chk("R5 write of 1 ignored", tx_flag, 1);
    wr(2'b10);
    chk("R5 tx cleared", tx_flag, 0);
    tx_count = 8; @(negedge clk);
    rd(0, d); wr(2'b10);
    chk("R7 tx reasserts under level", tx_flag, 1);
    tx_count = 9; @(negedge clk);
    wr(2'b10);
    chk("R6 second clear needs new read", tx_flag, 1);
    rd(0, d); wr(2'b10);
    chk("R5 tx cleared after read", tx_flag, 0);
    rx_sel = 1; rx_count = 5; @(negedge clk);
    rd(0, d); chk("R8 status rx bit", d, 16'h0002);
    wr(2'b00);
    chk("R7 rx reasserts under level", rx_flag, 1);
  endtask

  task automatic t_counts;
    logic [15:0] d;
    tx_count = 16; rx_count = 0; rd(1, d); chk("R8 count pack a", d, 16'h1000);
    tx_count = 3; rx_count = 14; rd(1, d); chk("R8 count pack b", d, 16'h030E);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    rx_ie = 0; tx_ie = 0; #1 chk("R9 disabled", irq, 0);
    rx_ie = 1; #1 chk("R9 rx enabled", irq, 1);
    rx_count = 0; @(negedge clk); rd(0, d); wr(2'b01);
    chk("R9 rx flag clear", rx_flag, 0);
    #1 chk("R9 irq drops", irq, 0);
    tx_ie = 1; tx_count = 1; @(negedge clk); #1 chk("R9 tx enabled", irq, 1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_tx_levels; t_rx_levels; t_handshake; t_counts; t_irq;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule